// File: doc/BRIEF.md
# On/Off Cycle-Skipping Switch Controller

This block decides, once per switching cycle, whether the external power switch is turned on. It runs its own cycle timer from the system clock. At each cycle start it reads a single regulation flag: if the flag is high, the gate enable is raised for that cycle, and if it is low, the whole cycle is skipped. Output regulation therefore comes from the pattern of enabled and skipped cycles, not from pulse-width modulation. A cycle that has been enabled ends early when the overcurrent flag asserts after a blanking interval, and ends in any case when the maximum on-window closes.

Several protection flags arrive from analog comparators as digital inputs. Supply undervoltage and over-temperature each have two thresholds, and each holds switching off until the recovery threshold is seen. A line-overvoltage flag that is present at two consecutive enabled cycle starts halts switching and raises an auto-restart request. An external off-timer ends the halt with a resume pulse. Soft-start stretches the cycle to twice its length, both after reset and after every resume. It ends after a fixed number of cycles, or earlier at the first cycle that is skipped for regulation.

Top module: `onoff_switch_ctrl`

## Requirements
- R1: After reset is released, cycle starts fall on the first clock edge and then every 2*PERIOD clocks while soft-start is active, or every PERIOD clocks otherwise. At a cycle start with fb_reg high, gate_en is high from that edge on. At a cycle start with fb_reg low, gate_en stays low for the whole cycle.
- R2: A change of fb_reg after the cycle-start edge does not change gate_en in that cycle.
- R3: gate_en is high for at most DCMAX clocks per cycle and falls at the DCMAX-th edge after the cycle start.
- R4: oc_flag high while gate_en is high and more than BLANK clocks have passed since turn-on clears gate_en at the next edge. gate_en then stays low until the next cycle start.
- R5: oc_flag is ignored during the first BLANK clocks of gate_en being high.
- R6: ss_active is high after reset. It falls at the start of cycle SS_CYCLES+1, counted from the start of soft-start.
- R7: A cycle start with fb_reg low while soft-start is active ends soft-start at that edge. That cycle and all later ones use the normal length.
- R8: If fb_shut is high at two consecutive cycle starts that are both enabled, the second of those cycles is not switched. ar_req then rises, and gate_en stays low with no further cycle starts until a resume. A skipped cycle between two such starts resets the count.
- R9: An ar_resume pulse while ar_req is high clears ar_req at the next edge and restarts soft-start. The first new cycle starts one edge later.
- R10: supply_lo high blocks switching. The block stays in place, even once supply_lo is low again, until supply_ok is seen high. A block that arrives during an enabled cycle clears gate_en within two edges.
- R11: temp_hot high blocks switching until temp_cool is seen high. It takes effect on an enabled cycle in the same way as R10.
- R12: While rst_n is low, gate_en and ar_req are low and ss_active is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge |
| fb_reg | input | 1 | Regulation flag; high requests a switched cycle |
| oc_flag | input | 1 | Switch current above the limit |
| fb_shut | input | 1 | Feedback current above the line-overvoltage level |
| supply_lo | input | 1 | Internal supply below its lower threshold |
| supply_ok | input | 1 | Internal supply above its upper threshold |
| temp_hot | input | 1 | Die temperature above the shutdown threshold |
| temp_cool | input | 1 | Die temperature below the recovery threshold |
| ar_resume | input | 1 | End of the external auto-restart off time |
| gate_en | output | 1 | Power switch enable |
| ar_req | output | 1 | Halted, auto-restart off period requested |
| ss_active | output | 1 | Soft-start in progress |

## Verification
The bench builds the block with PERIOD=8, DCMAX=5, BLANK=2 and SS_CYCLES=4. With a 16-clock soft-start cycle and an 8-clock normal cycle, every cycle start can be predicted by plain arithmetic from the release of reset. This puts the full soft-start sequence, its early exit, both protection hysteresis loops, a line-overvoltage streak broken by a skipped cycle, and a halt and resume within a few hundred clocks. Each edge of the blanking window and of the on-window is then checked at its exact clock.

// File: rtl/sw_ctrl_pkg.sv
package sw_ctrl_pkg;
  typedef enum logic {RUN_ON = 1'b0, RUN_HALTED = 1'b1} run_state_e;
endpackage

// File: rtl/cycle_timer.sv
module cycle_timer #(
  parameter int PERIOD = 1500,
  localparam int CW = $clog2(2 * PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          slow,
  output logic [CW-1:0] pos,
  output logic          cyc_start
);
  localparam logic [CW-1:0] LAST_SLOW = CW'(2 * PERIOD - 1);
  localparam logic [CW-1:0] LAST_FAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  always_comb begin
    wrap  = (cnt_q == (slow ? LAST_SLOW : LAST_FAST));
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pos       = cnt_q;
  assign cyc_start = run && (cnt_q == '0);
endmodule

// File: rtl/hyst_latch.sv
module hyst_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic recover,
  output logic blocked
);
  logic q, d;

  always_comb begin
    d = q;
    if (trip)         d = 1'b1;
    else if (recover) d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end

  assign blocked = q;
endmodule

// File: rtl/softstart_ctl.sv
module softstart_ctl #(
  parameter int SS_CYCLES = 256,
  localparam int SW = $clog2(SS_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic cyc_start,
  input  logic skip,
  output logic active
);
  localparam logic [SW-1:0] DONE_CNT = SW'(SS_CYCLES);

  logic          act_q, act_d;
  logic [SW-1:0] n_q, n_d;

  always_comb begin
    act_d = act_q;
    n_d   = n_q;
    if (restart) begin
      act_d = 1'b1;
      n_d   = '0;
    end else if (act_q && cyc_start) begin
      if (skip || n_q == DONE_CNT) act_d = 1'b0;
      else                         n_d   = n_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b1;
      n_q   <= '0;
    end else begin
      act_q <= act_d;
      n_q   <= n_d;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/onoff_switch_ctrl.sv
module onoff_switch_ctrl
  import sw_ctrl_pkg::*;
#(
  parameter int PERIOD    = 1500,
  parameter int DCMAX     = 975,
  parameter int BLANK     = 20,
  parameter int SS_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_reg,
  input  logic oc_flag,
  input  logic fb_shut,
  input  logic supply_lo,
  input  logic supply_ok,
  input  logic temp_hot,
  input  logic temp_cool,
  input  logic ar_resume,
  output logic gate_en,
  output logic ar_req,
  output logic ss_active
);
  localparam int CW = $clog2(2 * PERIOD);
  localparam logic [CW-1:0] DC_END  = CW'(DCMAX);
  localparam logic [CW-1:0] BLK_END = CW'(BLANK);

  logic [CW-1:0] pos;
  logic          cyc_start, uv_blk, ot_blk, blocked;
  logic          en_now, sd_hit, trip, resume_ok;
  logic          gate_q, gate_d, streak_q, streak_d;
  run_state_e    st_q, st_d;

  cycle_timer #(.PERIOD(PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(st_q == RUN_ON), .slow(ss_active),
    .pos(pos), .cyc_start(cyc_start));

  hyst_latch u_uv (.clk(clk), .rst_n(rst_n), .trip(supply_lo),
                   .recover(supply_ok), .blocked(uv_blk));
  hyst_latch u_ot (.clk(clk), .rst_n(rst_n), .trip(temp_hot),
                   .recover(temp_cool), .blocked(ot_blk));

  assign blocked   = uv_blk | ot_blk;
  assign resume_ok = ar_resume && (st_q == RUN_HALTED);

  softstart_ctl #(.SS_CYCLES(SS_CYCLES)) u_ss (
    .clk(clk), .rst_n(rst_n), .restart(resume_ok), .cyc_start(cyc_start),
    .skip(!fb_reg), .active(ss_active));

  always_comb begin
    en_now   = fb_reg && !blocked && (st_q == RUN_ON);
    sd_hit   = cyc_start && en_now && fb_shut;
    trip     = sd_hit && streak_q;
    streak_d = streak_q;
    st_d     = st_q;
    if (resume_ok) begin
      st_d     = RUN_ON;
      streak_d = 1'b0;
    end else if (cyc_start) begin
      streak_d = sd_hit;
      if (trip) st_d = RUN_HALTED;
    end

    gate_d = gate_q;
    if (cyc_start)                                     gate_d = en_now && !trip;
    else if (blocked || st_q == RUN_HALTED)            gate_d = 1'b0;
    else if (gate_q && pos == DC_END)                  gate_d = 1'b0;
    else if (gate_q && oc_flag && pos > BLK_END)       gate_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q   <= 1'b0;
      streak_q <= 1'b0;
      st_q     <= RUN_ON;
    end else begin
      gate_q   <= gate_d;
      streak_q <= streak_d;
      st_q     <= st_d;
    end
  end

  assign gate_en = gate_q;
  assign ar_req  = (st_q == RUN_HALTED);
endmodule

// File: rtl/onoff_switch_ctrl_chk.sv
module onoff_switch_ctrl_chk #(
  parameter int CW    = 4,
  parameter int DCMAX = 5,
  parameter int BLANK = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gate_en,
  input logic          ar_req,
  input logic          oc_flag,
  input logic          fb_reg,
  input logic          cyc_start,
  input logic          blocked,
  input logic [CW-1:0] pos
);
  a_r3_on_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !cyc_start && pos == CW'(DCMAX)) |=> !gate_en);

  a_r4_overcurrent_cuts: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !cyc_start && oc_flag && pos > CW'(BLANK)) |=> !gate_en);

  a_r5_blanking_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !cyc_start && !blocked && !ar_req && pos >= CW'(1) &&
     pos <= CW'(BLANK) && pos < CW'(DCMAX)) |=> gate_en);

  a_r1_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> $past(cyc_start && fb_reg));

  a_r8_halt_off: assert property (@(posedge clk) disable iff (!rst_n)
    ar_req |-> !gate_en);

  a_r10_block_off: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && !cyc_start) |=> !gate_en);
endmodule

bind onoff_switch_ctrl onoff_switch_ctrl_chk #(.CW(CW), .DCMAX(DCMAX), .BLANK(BLANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .ar_req(ar_req), .oc_flag(oc_flag),
  .fb_reg(fb_reg), .cyc_start(cyc_start), .blocked(blocked), .pos(pos));

// File: tb/sim_onoff_switch_ctrl.sv
`timescale 1ns/1ps
module sim_onoff_switch_ctrl;
  logic clk = 1'b0;
  logic rst_n, fb_reg, oc_flag, fb_shut, supply_lo, supply_ok;
  logic temp_hot, temp_cool, ar_resume;
  logic gate_en, ar_req, ss_active;
  int   ecount = 0;
  int   checks = 0;
  int   errors = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst_n) ecount++;

  onoff_switch_ctrl #(.PERIOD(8), .DCMAX(5), .BLANK(2), .SS_CYCLES(4)) u0 (
    .clk(clk), .rst_n(rst_n), .fb_reg(fb_reg), .oc_flag(oc_flag), .fb_shut(fb_shut),
    .supply_lo(supply_lo), .supply_ok(supply_ok), .temp_hot(temp_hot),
    .temp_cool(temp_cool), .ar_resume(ar_resume), .gate_en(gate_en),
    .ar_req(ar_req), .ss_active(ss_active));

  task automatic at(input int n);
    while (ecount < n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at edge %0d: actual %b expected %b", req, ecount, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fb_reg = 1'b1; oc_flag = 1'b0; fb_shut = 1'b0;
    supply_lo = 1'b0; supply_ok = 1'b1; temp_hot = 1'b0; temp_cool = 1'b1;
    ar_resume = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 gate", gate_en, 1'b0);
    chk("R12 ar_req", ar_req, 1'b0);
    chk("R12 ss", ss_active, 1'b1);
    rst_n = 1'b1;
    // soft-start cycles begin at edges 1, 17, 33, 49; normal ones from 65
    at(1);  chk("R1 first start", gate_en, 1'b1);
    at(5);  chk("R3 still on", gate_en, 1'b1);
    at(6);  chk("R3 window closed", gate_en, 1'b0);
    at(16); chk("R1 slow period gap", gate_en, 1'b0);
    at(17); chk("R1 slow period start", gate_en, 1'b1);
    oc_flag = 1'b1;
    at(19); chk("R5 blanked", gate_en, 1'b1);
    at(20); chk("R4 overcurrent cut", gate_en, 1'b0);
    at(21); oc_flag = 1'b0;
    at(22); chk("R4 stays off", gate_en, 1'b0);
    at(64); chk("R6 still soft", ss_active, 1'b1);
    at(65); chk("R6 soft ended", ss_active, 1'b0);
    chk("R1 normal start", gate_en, 1'b1);
    at(72); chk("R1 fast gap", gate_en, 1'b0);
    at(73); chk("R1 fast start", gate_en, 1'b1);
    fb_reg = 1'b0;
    at(81); chk("R1 skipped", gate_en, 1'b0);
    fb_reg = 1'b1;
    at(84); chk("R2 late rise ignored", gate_en, 1'b0);
    at(89); chk("R1 resumed", gate_en, 1'b1);
    fb_reg = 1'b0;
    at(92); chk("R2 late fall ignored", gate_en, 1'b0 ^ 1'b1);
    fb_reg = 1'b1;
    // supply undervoltage hysteresis
    at(102); supply_lo = 1'b1; supply_ok = 1'b0;
    at(103); supply_lo = 1'b0;
    at(105); chk("R10 blocked", gate_en, 1'b0);
    at(113); chk("R10 between thresholds", gate_en, 1'b0);
    supply_ok = 1'b1;
    at(121); chk("R10 recovered", gate_en, 1'b1);
    temp_hot = 1'b1; temp_cool = 1'b0;
    at(123); chk("R11 kills on-cycle", gate_en, 1'b0);
    temp_hot = 1'b0;
    at(129); chk("R11 blocked", gate_en, 1'b0);
    at(137); chk("R11 between thresholds", gate_en, 1'b0);
    temp_cool = 1'b1;
    at(145); chk("R11 recovered", gate_en, 1'b1);
    // line overvoltage with a broken streak
    fb_shut = 1'b1;
    at(153); chk("R8 first hit switches", gate_en, 1'b1);
    fb_reg = 1'b0;
    at(161); fb_reg = 1'b1;
    at(169); chk("R8 broken streak", gate_en, 1'b1);
    chk("R8 no request yet", ar_req, 1'b0);
    at(177); chk("R8 tripped gate", gate_en, 1'b0);
    chk("R8 request", ar_req, 1'b1);
    at(184); chk("R8 halted", gate_en, 1'b0);
    fb_shut = 1'b0;
    at(185); ar_resume = 1'b1;
    at(186); ar_resume = 1'b0;
    chk("R9 request cleared", ar_req, 1'b0);
    chk("R9 soft restarted", ss_active, 1'b1);
    at(187); chk("R9 first new cycle", gate_en, 1'b1);
    at(202); chk("R9 slow gap", gate_en, 1'b0);
    at(203); chk("R9 slow start", gate_en, 1'b1);
    fb_reg = 1'b0;
    at(219); chk("R7 soft ended early", ss_active, 1'b0);
    chk("R7 skipped", gate_en, 1'b0);
    fb_reg = 1'b1;
    at(226); chk("R7 normal gap", gate_en, 1'b0);
    at(227); chk("R7 normal start", gate_en, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule